// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC, where the destination field of an arriving frame has just been collected. On a one-cycle strobe it looks at the 48-bit destination and decides whether the frame is kept. If it is kept, the block also picks which of eight receive channels the frame goes to.

The destination is sorted into one of three classes: broadcast (all ones), multicast (group bit set) or unicast. Each class is then judged against a small register set, which holds the following:

- a station address for exact unicast matching
- a per-channel unicast enable mask
- a 64-bucket multicast table, indexed by a 6-bit hash that folds the address bytes with shifts and XOR
- control bits for accepting broadcast, accepting multicast, and promiscuous mode

Promiscuous mode takes priority over every other rule. The decision, the reason for it and the channel number come out registered, one cycle after the strobe.

Top module: `rx_dest_filter`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. Every strobe produces exactly one result, and results come out in strobe order.
- R2: A write selects a register with `cfg_addr`:
  - 0: control word
  - 1: station bytes 0..3 (byte 0 in bits 7:0)
  - 2: station byte 4 (bits 7:0)
  - 3: station byte 5 (bits 7:0)
  - 4: hash buckets 0..31
  - 5: hash buckets 32..63
  - 6: unicast-enable set
  - 7: unicast-enable clear

  A strobe in the same cycle as a write is judged with the values from before that write.
- R3: When control bit 21 is set, every frame is accepted with reason 3 (promiscuous) and the channel from control bits 18:16. This rule takes priority over all the others.
- R4: A destination of all ones is broadcast, reported with reason 1. It is accepted only when control bit 13 is set, and then gets the channel from control bits 10:8.
- R5: A destination that is not broadcast and has bit 0 of byte 0 set is multicast, reported with reason 2. It is accepted only when control bit 5 is set and the table bit at its hash bucket is 1. It then gets the channel from control bits 2:0.
- R6: The hash is computed over bytes i = 0..5 with 8-bit arithmetic, and only bits 5:0 of the XOR of all six terms are kept. Byte i of `in_dst` sits in bits 8i+7:8i. Each term depends on i mod 3:
  - i mod 3 = 0: (b>>2)^(b<<4)
  - i mod 3 = 1: (b>>4)^(b<<2)
  - i mod 3 = 2: (b>>6)^b
- R7: With both hash words all ones and multicast enabled, every multicast destination is accepted.
- R8: Any other destination is unicast, reported with reason 0. It is accepted only when all six bytes equal the station address and the unicast-enable mask is nonzero. The channel is the index of the lowest set bit of the mask.
- R9: Writing ones to the set register sets those mask bits. Writing ones to the clear register clears them. Once every channel is cleared, matching unicast frames are rejected.
- R10: A rejected frame shows `out_accept` = 0 and `out_chan` = 0, and `out_reason` still gives its class.
- R11: After reset all registers are zero and `out_valid` is low. A unicast frame arriving before any configuration is therefore rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Destination address valid strobe |
| in_dst | input | 48 | Destination address, byte 0 in bits 7:0 |
| out_valid | output | 1 | Decision valid, one cycle after strobe |
| out_accept | output | 1 | Frame accepted |
| out_reason | output | 2 | 0 unicast, 1 broadcast, 2 multicast, 3 promiscuous |
| out_chan | output | 3 | Receive channel, zero on reject |

## Verification
A register write and an address strobe can land in the same cycle, and the block must then use the configuration from before the write. The bench provokes this by driving a strobe together with the control write that turns promiscuous mode off. The expected result is predicted from the bench's shadow registers before they are updated. A strobe on the following cycle must then show the new rule. The same overlap is also driven with a unicast-clear write that removes the last enabled channel.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = MAC_BYTES * 8;
    localparam int HASH_W    = 6;
    localparam int HASH_ENT  = 1 << HASH_W;
    localparam int CHAN_CNT  = 8;
    localparam int CHAN_W    = $clog2(CHAN_CNT);
    localparam int REG_W     = 32;
    localparam int REG_AW    = 3;

    // control word field positions
    localparam int PROM_EN_BIT = 21;
    localparam int PROM_CH_LSB = 16;
    localparam int BC_EN_BIT   = 13;
    localparam int BC_CH_LSB   = 8;
    localparam int MC_EN_BIT   = 5;
    localparam int MC_CH_LSB   = 0;

    typedef enum logic [REG_AW-1:0] {
        REG_CTRL    = 3'd0,
        REG_STA_HI  = 3'd1,
        REG_STA_MID = 3'd2,
        REG_STA_LO  = 3'd3,
        REG_HASH_LO = 3'd4,
        REG_HASH_HI = 3'd5,
        REG_UC_SET  = 3'd6,
        REG_UC_CLR  = 3'd7
    } cfg_reg_e;

    typedef enum logic [1:0] {
        RSN_UCAST   = 2'd0,
        RSN_BCAST   = 2'd1,
        RSN_MCAST   = 2'd2,
        RSN_PROMISC = 2'd3
    } reason_e;

    typedef struct packed {
        logic                prom_en;
        logic [CHAN_W-1:0]   prom_ch;
        logic                bc_en;
        logic [CHAN_W-1:0]   bc_ch;
        logic                mc_en;
        logic [CHAN_W-1:0]   mc_ch;
        logic [MAC_W-1:0]    station;
        logic [HASH_ENT-1:0] hash_tbl;
        logic [CHAN_CNT-1:0] uc_mask;
    } filt_cfg_t;

    typedef struct packed {
        logic              is_bcast;
        logic              is_mcast;
        logic              sta_hit;
        logic [HASH_W-1:0] bucket;
    } addr_class_t;

    // shift/XOR fold of the six address bytes into a bucket index
    function automatic logic [HASH_W-1:0] hash_fold(input logic [MAC_W-1:0] a);
        logic [7:0] acc;
        logic [7:0] b;
        acc = '0;
        for (int i = 0; i < MAC_BYTES; i++) begin
            b = a[8*i +: 8];
            case (i % 3)
                0:       acc = acc ^ ((b >> 2) ^ (b << 4));
                1:       acc = acc ^ ((b >> 4) ^ (b << 2));
                default: acc = acc ^ ((b >> 6) ^ b);
            endcase
        end
        return acc[HASH_W-1:0];
    endfunction

    function automatic logic [CHAN_W-1:0] lowest_set(input logic [CHAN_CNT-1:0] m);
        logic [CHAN_W-1:0] idx;
        idx = '0;
        for (int i = CHAN_CNT - 1; i >= 0; i--) begin
            if (m[i]) idx = CHAN_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_AW-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    output filt_cfg_t            cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (cfg_reg_e'(addr))
                REG_CTRL: begin
                    cfg.prom_en <= wdata[PROM_EN_BIT];
                    cfg.prom_ch <= wdata[PROM_CH_LSB +: CHAN_W];
                    cfg.bc_en   <= wdata[BC_EN_BIT];
                    cfg.bc_ch   <= wdata[BC_CH_LSB +: CHAN_W];
                    cfg.mc_en   <= wdata[MC_EN_BIT];
                    cfg.mc_ch   <= wdata[MC_CH_LSB +: CHAN_W];
                end
                REG_STA_HI:  cfg.station[31:0]            <= wdata;
                REG_STA_MID: cfg.station[39:32]           <= wdata[7:0];
                REG_STA_LO:  cfg.station[47:40]           <= wdata[7:0];
                REG_HASH_LO: cfg.hash_tbl[31:0]           <= wdata;
                REG_HASH_HI: cfg.hash_tbl[HASH_ENT-1:32]  <= wdata;
                REG_UC_SET:  cfg.uc_mask <= cfg.uc_mask | wdata[CHAN_CNT-1:0];
                REG_UC_CLR:  cfg.uc_mask <= cfg.uc_mask & ~wdata[CHAN_CNT-1:0];
                default: ;
            endcase
        end
    end

    // R9
    uc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == REG_UC_CLR) |=> ((cfg.uc_mask & $past(wdata[CHAN_CNT-1:0])) == '0));

    // R9
    uc_set_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == REG_UC_SET) |=> ((cfg.uc_mask & $past(wdata[CHAN_CNT-1:0])) == $past(wdata[CHAN_CNT-1:0])));

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
    import rxf_pkg::*;
(
    input  logic [MAC_W-1:0] dst,
    input  filt_cfg_t        cfg,
    output addr_class_t      cls
);

    logic [MAC_BYTES-1:0] byte_eq;
    logic [MAC_BYTES-1:0] byte_ones;

    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_byte
        assign byte_eq[g]   = (dst[8*g +: 8] == cfg.station[8*g +: 8]);
        assign byte_ones[g] = &dst[8*g +: 8];
    end

    always_comb begin
        cls.is_bcast = &byte_ones;
        cls.is_mcast = dst[0] && !cls.is_bcast;
        cls.sta_hit  = &byte_eq;
        cls.bucket   = hash_fold(dst);
    end

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int N_CHAN = CHAN_CNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  addr_class_t       cls,
    input  filt_cfg_t         cfg,
    output logic              out_valid,
    output logic              out_accept,
    output reason_e           out_reason,
    output logic [CHAN_W-1:0] out_chan
);

    localparam int CW = $clog2(N_CHAN);

    logic          nxt_acc;
    reason_e       nxt_rsn;
    logic [CW-1:0] nxt_ch;
    logic          mc_hit;

    always_comb begin
        mc_hit  = cfg.mc_en && cfg.hash_tbl[cls.bucket];
        nxt_acc = 1'b0;
        nxt_rsn = RSN_UCAST;
        nxt_ch  = '0;
        if (cfg.prom_en) begin
            nxt_acc = 1'b1;
            nxt_rsn = RSN_PROMISC;
            nxt_ch  = cfg.prom_ch;
        end else if (cls.is_bcast) begin
            nxt_rsn = RSN_BCAST;
            nxt_acc = cfg.bc_en;
            nxt_ch  = cfg.bc_en ? cfg.bc_ch : '0;
        end else if (cls.is_mcast) begin
            nxt_rsn = RSN_MCAST;
            nxt_acc = mc_hit;
            nxt_ch  = mc_hit ? cfg.mc_ch : '0;
        end else begin
            nxt_rsn = RSN_UCAST;
            nxt_acc = cls.sta_hit && (|cfg.uc_mask);
            nxt_ch  = nxt_acc ? lowest_set(cfg.uc_mask) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_accept <= 1'b0;
            out_reason <= RSN_UCAST;
            out_chan   <= '0;
        end else begin
            out_valid  <= in_valid;
            out_accept <= in_valid && nxt_acc;
            out_reason <= in_valid ? nxt_rsn : RSN_UCAST;
            out_chan   <= in_valid ? nxt_ch : '0;
        end
    end

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3
    promisc_override_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg.prom_en) |=> (out_accept && out_reason == RSN_PROMISC));

    // R5
    mcast_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cfg.prom_en && cls.is_mcast && !cfg.hash_tbl[cls.bucket]) |=> !out_accept);

    // R4
    bcast_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cfg.prom_en && cls.is_bcast && !cfg.bc_en) |=> (!out_accept && out_reason == RSN_BCAST));

    // R9
    uc_empty_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cfg.prom_en && !cls.is_bcast && !cls.is_mcast && cfg.uc_mask == '0) |=> !out_accept);

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        in_valid,
    input  logic [47:0] in_dst,
    output logic        out_valid,
    output logic        out_accept,
    output logic [1:0]  out_reason,
    output logic [2:0]  out_chan
);

    filt_cfg_t   cfg;
    addr_class_t cls;
    reason_e     rsn;

    rxf_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    rxf_classify u_class (
        .dst (in_dst),
        .cfg (cfg),
        .cls (cls)
    );

    rxf_decide #(.N_CHAN(CHAN_CNT)) u_decide (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .cls        (cls),
        .cfg        (cfg),
        .out_valid  (out_valid),
        .out_accept (out_accept),
        .out_reason (rsn),
        .out_chan   (out_chan)
    );

    assign out_reason = rsn;

    // R10
    reject_chan_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_accept) |-> (out_chan == 3'd0));

endmodule

// File: tb/tb_rx_dest_filter.sv
module tb_rx_dest_filter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [47:0] in_dst = '0;
    logic        out_valid;
    logic        out_accept;
    logic [1:0]  out_reason;
    logic [2:0]  out_chan;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_dest_filter dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_dst(in_dst),
        .out_valid(out_valid), .out_accept(out_accept),
        .out_reason(out_reason), .out_chan(out_chan)
    );

    typedef struct {
        bit       acc;
        bit [1:0] rsn;
        bit [2:0] ch;
        string    tag;
    } exp_t;

    exp_t sb[$];

    bit [31:0] s_ctrl = '0;
    bit [47:0] s_sta  = '0;
    bit [63:0] s_hash = '0;
    bit [7:0]  s_uc   = '0;

    function automatic bit [5:0] tb_hash(bit [47:0] a);
        bit [7:0] x;
        bit [7:0] t;
        x = 8'h00;
        for (int i = 0; i < 6; i++) begin
            t = a[i*8 +: 8];
            if (i == 0 || i == 3)      x ^= {t[3:0], 4'b0} ^ {2'b0, t[7:2]};
            else if (i == 1 || i == 4) x ^= {t[5:0], 2'b0} ^ {4'b0, t[7:4]};
            else                       x ^= t ^ {6'b0, t[7:6]};
        end
        return x[5:0];
    endfunction

    function automatic exp_t predict(bit [47:0] a, string tag);
        exp_t e;
        bit bc;
        bit mc;
        e.tag = tag; e.acc = 0; e.ch = 0; e.rsn = 0;
        bc = (a == 48'hFFFF_FFFF_FFFF);
        mc = a[0] && !bc;
        if (s_ctrl[21]) begin
            e.acc = 1; e.rsn = 3; e.ch = s_ctrl[18:16];
        end else if (bc) begin
            e.rsn = 1; e.acc = s_ctrl[13]; e.ch = e.acc ? s_ctrl[10:8] : 3'd0;
        end else if (mc) begin
            e.rsn = 2; e.acc = s_ctrl[5] && s_hash[tb_hash(a)]; e.ch = e.acc ? s_ctrl[2:0] : 3'd0;
        end else begin
            e.rsn = 0; e.acc = (a == s_sta) && (s_uc != 0);
            if (e.acc) begin
                for (int k = 7; k >= 0; k--) if (s_uc[k]) e.ch = 3'(k);
            end
        end
        return e;
    endfunction

    task automatic shadow_apply(bit [2:0] ad, bit [31:0] d);
        case (ad)
            3'd0: s_ctrl = d;
            3'd1: s_sta[31:0] = d;
            3'd2: s_sta[39:32] = d[7:0];
            3'd3: s_sta[47:40] = d[7:0];
            3'd4: s_hash[31:0] = d;
            3'd5: s_hash[63:32] = d;
            3'd6: s_uc = s_uc | d[7:0];
            default: s_uc = s_uc & ~d[7:0];
        endcase
    endtask

    task automatic cfg_write(bit [2:0] ad, bit [31:0] d);
        @(negedge clk);
        in_valid = 0; cfg_we = 1; cfg_addr = ad; cfg_wdata = d;
        shadow_apply(ad, d);
    endtask

    task automatic send(bit [47:0] a, string tag);
        @(negedge clk);
        cfg_we = 0; in_valid = 1; in_dst = a;
        sb.push_back(predict(a, tag));
    endtask

    task automatic send_with_write(bit [47:0] a, bit [2:0] ad, bit [31:0] d, string tag);
        @(negedge clk);
        in_valid = 1; in_dst = a; cfg_we = 1; cfg_addr = ad; cfg_wdata = d;
        sb.push_back(predict(a, tag));
        shadow_apply(ad, d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; cfg_we = 0;
        end
    endtask

    function automatic bit [31:0] ctrl_word(bit pe, bit [2:0] pc, bit be, bit [2:0] bch, bit me, bit [2:0] mch);
        bit [31:0] w;
        w = '0;
        w[21] = pe; w[18:16] = pc;
        w[13] = be; w[10:8] = bch;
        w[5] = me;  w[2:0] = mch;
        return w;
    endfunction

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                checks++;
                if (sb.size() == 0) begin
                    failures++;
                    $display("FAIL R1 unexpected result acc=%0d rsn=%0d ch=%0d expected none",
                             out_accept, out_reason, out_chan);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (out_accept !== e.acc || out_reason !== e.rsn || out_chan !== e.ch) begin
                        failures++;
                        $display("FAIL %s acc=%0d rsn=%0d ch=%0d expected acc=%0d rsn=%0d ch=%0d",
                                 e.tag, out_accept, out_reason, out_chan, e.acc, e.rsn, e.ch);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam bit [47:0] STA   = 48'h55_44_33_22_11_02;
    localparam bit [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    initial begin
        bit [47:0] m0;
        bit [47:0] m1;
        bit [63:0] tbl;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R11 out_valid=%0b expected 0 in reset", out_valid);
        end
        rst = 0;
        idle(1);
        send(48'h0, "R11 unconfigured unicast rejected");
        idle(2);

        // station and unicast mask
        cfg_write(3'd1, STA[31:0]);
        cfg_write(3'd2, {24'h0, STA[39:32]});
        cfg_write(3'd3, {24'h0, STA[47:40]});
        cfg_write(3'd6, 32'h0000_000C);
        send(STA, "R8 unicast match lowest channel");
        send(STA ^ 48'h01_00_00_00_00_00, "R10 unicast last byte mismatch");
        send(STA ^ 48'h00_00_00_00_00_04, "R10 unicast first byte mismatch");
        send(STA, "R1 back-to-back strobe");
        cfg_write(3'd7, 32'h0000_0004);
        send(STA, "R9 clear moves to next channel");
        cfg_write(3'd7, 32'h0000_0008);
        send(STA, "R9 all channels cleared reject");
        cfg_write(3'd6, 32'h0000_0081);
        send(STA, "R9 set restores channel 0");

        // broadcast
        send(BCAST, "R4 broadcast disabled");
        cfg_write(3'd0, ctrl_word(0, 3'd0, 1, 3'd5, 0, 3'd0));
        send(BCAST, "R4 broadcast enabled");
        send(STA, "R8 unicast with broadcast on");

        // multicast single buckets
        m0 = 48'h01_00_00_5E_00_01;
        m1 = 48'hA7_31_9C_22_4B_03;
        tbl = '0;
        tbl[tb_hash(m0)] = 1'b1;
        tbl[tb_hash(m1)] = 1'b1;
        cfg_write(3'd4, tbl[31:0]);
        cfg_write(3'd5, tbl[63:32]);
        send(m0, "R5 multicast disabled");
        cfg_write(3'd0, ctrl_word(0, 3'd0, 1, 3'd5, 1, 3'd6));
        send(m0, "R6 multicast bucket hit");
        send(m1, "R6 multicast second bucket hit");
        for (int i = 0; i < 24; i++) begin
            send({8'(i*37 + 5), 8'(i*11), 8'(i + 3), 8'(i*73), 8'h5E, 8'(8'h01 | 8'(i << 1))},
                 "R6 multicast hash sweep");
        end
        send(BCAST, "R4 broadcast not multicast");

        // all multicast
        cfg_write(3'd4, 32'hFFFF_FFFF);
        cfg_write(3'd5, 32'hFFFF_FFFF);
        for (int i = 0; i < 16; i++) begin
            send({8'(i*29), 8'(i*3 + 1), 8'(i*101), 8'(i*7), 8'(i*13), 8'(8'h01 | 8'(i*6))},
                 "R7 all-ones table accepts");
        end

        // promiscuous
        cfg_write(3'd0, ctrl_word(1, 3'd7, 1, 3'd5, 1, 3'd6));
        send(STA ^ 48'h10_00_00_00_00_00, "R3 promiscuous foreign unicast");
        send(BCAST, "R3 promiscuous overrides broadcast");
        send(m0, "R3 promiscuous overrides multicast");

        // same-cycle write and strobe
        send_with_write(STA ^ 48'h20_00_00_00_00_00, 3'd0, ctrl_word(0, 3'd0, 1, 3'd5, 1, 3'd6),
                        "R2 strobe with write uses old control");
        send(STA ^ 48'h20_00_00_00_00_00, "R2 next strobe uses new control");
        send_with_write(STA, 3'd7, 32'h0000_00FF, "R2 strobe with clear uses old mask");
        send(STA, "R2 next strobe sees cleared mask");
        idle(4);

        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R1 %0d results missing expected 0", sb.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule